// File: doc/BRIEF.md
# Auto-Reload 16-bit Timer/Counter

This block is a 16-bit up-counter that is paired with a 16-bit reload value and an 8-bit control register. It counts in one of two ways. In timer mode it counts a machine-cycle tick, which is the core clock divided by twelve and is supplied from outside the block. In counter mode it counts falling edges seen on an external count pin. An external gate pin can also hold counting off. When the count wraps past all ones, the counter loads itself from the reload value and raises an overflow flag. That flag goes to an interrupt controller, and the controller clears it with a strobe once it has taken the interrupt. The reload value itself never changes on a wrap.

Software reaches the block through a plain register port. A write is accepted on every clock in which `wr_en` is high, and there is no back-pressure and no handshake. A read is a combinational lookup from `rd_addr`. The tick, the pins, the flag and the flag-clear strobe are plain level signals. No data stream passes through the block, so there is no valid/ready interface.

Top module: `reload_timer16`

## Requirements
- R1: After reset, the control register, both count bytes and both reload bytes read 00h, and `ovf_flag` is low.
- R2: In timer mode (counter-select bit 0), with the run bit 1 and the gate bit 0, the count rises by exactly one on every clock where `mc_tick` is high.
- R3: In counter mode (counter-select bit 1), a falling edge of `ext_cnt_pin` is taken through a two-flop synchronizer and then held pending until the next `mc_tick`. Each tick consumes at most one pending edge, so any number of edges between two ticks give a single count.
- R4: When the gate bit is 1, counting happens only while the synchronized `ext_gate_pin` is high. While it is low, the count holds.
- R5: An increment from FFFFh loads the count with the reload value instead of wrapping to 0000h. Only software writes change the reload value.
- R6: The same clock edge that performs the reload also sets the overflow flag, and the flag is driven on `ovf_flag`.
- R7: A `flag_clr` strobe clears the flag. If an overflow happens in the same cycle as the strobe, the flag stays set.
- R8: A software write to a count byte in the same cycle as an increment takes priority. The written byte takes the written value, and no increment happens in that cycle.
- R9: The control register bits, from bit 7 down to bit 0, are: gate, counter-select, overflow flag, run, and four plain storage bits that read back as written. A software write to bit 5 loads the flag only when neither an overflow nor a clear strobe happens in that cycle.
- R10: The register addresses are as follows:
  - 0: control
  - 1: count low byte
  - 2: count high byte
  - 3: reload low byte
  - 4: reload high byte

  Writes to addresses 5 to 7 have no effect, and reads from them return 00h.
- R11: With the run bit 0, the count holds its value except when software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | One-clock machine-cycle tick (clock divided by 12) |
| ext_cnt_pin | input | 1 | External count input; asynchronous |
| ext_gate_pin | input | 1 | External gate input; asynchronous |
| flag_clr | input | 1 | Flag-clear strobe from the interrupt controller |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| ovf_flag | output | 1 | Overflow flag / interrupt request |

## Verification
Each result has its own latency:
- A register write, a tick-driven increment, a reload and a flag change each show up on the read port one clock edge after the cycle that caused them.
- A level change on the gate pin takes two edges to reach the counter, so a count that depends on it comes on the third edge.
- A falling edge on the count pin needs three edges before it is recognised, and it is then counted at the next tick.

The bench keeps a behavioural reference model that is stepped on every rising edge. It samples every register and the flag half a period later, when all of these latencies have settled. The directed checks are timed in whole clock periods from the falling edge that drives each stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W    = 8;
  localparam int CTRL_ADDR = 0;

  typedef struct packed {
    logic       gate;
    logic       csel;
    logic       flag;
    logic       run;
    logic [3:0] spare;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wrap,
  input  logic              flag_clr,
  output tmr_ctrl_t         ctrl
);
  tmr_ctrl_t wr_view;
  assign wr_view = tmr_ctrl_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_sel) begin
        ctrl.gate  <= wr_view.gate;
        ctrl.csel  <= wr_view.csel;
        ctrl.run   <= wr_view.run;
        ctrl.spare <= wr_view.spare;
      end
      // overflow beats clear strobe, which beats a software write
      if (wrap)          ctrl.flag <= 1'b1;
      else if (flag_clr) ctrl.flag <= 1'b0;
      else if (wr_sel)   ctrl.flag <= wr_view.flag;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int CNT_BASE = 1,
  parameter int RLD_BASE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              inc,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rld,
  output logic              wrap
);
  localparam int NB = CNT_W / BYTE_W;

  logic [NB-1:0]    cnt_lane_wr;
  logic [NB-1:0]    rld_lane_wr;
  logic             any_cnt_wr;
  logic [CNT_W-1:0] cnt_nxt;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign cnt_lane_wr[b] = wr_en && (wr_addr == ADDR_W'(CNT_BASE + b));
    assign rld_lane_wr[b] = wr_en && (wr_addr == ADDR_W'(RLD_BASE + b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rld[b*BYTE_W +: BYTE_W] <= '0;
      else if (rld_lane_wr[b]) rld[b*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  assign any_cnt_wr = |cnt_lane_wr;
  assign wrap       = inc && !any_cnt_wr && (cnt == {CNT_W{1'b1}});

  always_comb begin
    cnt_nxt = cnt;
    if (any_cnt_wr) begin
      for (int b = 0; b < NB; b++)
        if (cnt_lane_wr[b]) cnt_nxt[b*BYTE_W +: BYTE_W] = wr_data;
    end else if (wrap) begin
      cnt_nxt = rld;
    end else if (inc) begin
      cnt_nxt = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              ext_cnt_pin,
  input  logic              ext_gate_pin,
  input  logic              flag_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              ovf_flag
);
  localparam int NB       = CNT_W / BYTE_W;
  localparam int CNT_BASE = CTRL_ADDR + 1;
  localparam int RLD_BASE = CNT_BASE + NB;

  tmr_ctrl_t        ctrl_q;
  logic             t0_sync, t0_prev, t0_fall;
  logic             gate_sync;
  logic             pend_q;
  logic             cnt_src, run_en, inc;
  logic             wrap;
  logic             tr_en;
  logic [CNT_W-1:0] cnt_val, rld_val;

  tmr_sync #(.STAGES(SYNC_STAGES)) u_t0_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_cnt_pin), .q(t0_sync)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_gate_pin), .q(gate_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_prev <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      t0_prev <= t0_sync;
      // an edge waits here until a tick consumes it
      pend_q  <= mc_tick ? 1'b0 : (pend_q | t0_fall);
    end
  end

  assign t0_fall = t0_prev & ~t0_sync;
  assign cnt_src = mc_tick & (ctrl_q.csel ? (pend_q | t0_fall) : 1'b1);
  assign tr_en   = ctrl_q.run;
  assign run_en  = tr_en & (~ctrl_q.gate | gate_sync);
  assign inc     = run_en & cnt_src;

  tmr_count_core #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE), .RLD_BASE(RLD_BASE)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .inc(inc), .cnt(cnt_val), .rld(rld_val), .wrap(wrap)
  );

  tmr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))),
    .wr_data(wr_data), .wrap(wrap), .flag_clr(flag_clr), .ctrl(ctrl_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = ctrl_q;
    for (int b = 0; b < NB; b++) begin
      if (rd_addr == ADDR_W'(CNT_BASE + b)) rd_data = cnt_val[b*BYTE_W +: BYTE_W];
      if (rd_addr == ADDR_W'(RLD_BASE + b)) rd_data = rld_val[b*BYTE_W +: BYTE_W];
    end
  end

  assign ovf_flag = ctrl_q.flag;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              flag_clr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  rld,
  input logic              tf,
  input logic              tr
);
  localparam int NB = CNT_W / 8;
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic cnt_wr, rld_wr, ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == '0);
  assign cnt_wr  = wr_en && (wr_addr >= ADDR_W'(1)) && (wr_addr <= ADDR_W'(NB));
  assign rld_wr  = wr_en && (wr_addr >= ADDR_W'(NB + 1)) && (wr_addr <= ADDR_W'(2 * NB));

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tr && !cnt_wr) |=> $stable(cnt)); // R11

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && cnt != ALL1) |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1))); // R2

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !ctrl_wr && cnt == ALL1 && !tf) |=> (tf ? (cnt == $past(rld)) : (cnt == $past(cnt)))); // R5

  AST_RELOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_wr |=> $stable(rld)); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && cnt != ALL1) |=> !tf); // R7
endmodule

bind reload_timer16 tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tmr_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .flag_clr(flag_clr),
  .cnt(cnt_val), .rld(rld_val), .tf(ovf_flag), .tr(tr_en)
);

// File: tb/test_reload_timer16.sv
`timescale 1ns/100ps
module test_reload_timer16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick = 1'b0, ext_cnt_pin = 1'b1, ext_gate_pin = 1'b0, flag_clr = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic ovf_flag;

  int checks = 0, errors = 0;
  int tick_mode = 1;
  int ph = 0;
  bit done = 0;
  logic [7:0] obs [0:7];

  always #4 clk = ~clk;

  reload_timer16 i_reload_timer16 (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_cnt_pin(ext_cnt_pin),
    .ext_gate_pin(ext_gate_pin), .flag_clr(flag_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  // reference model state
  logic [15:0] m_cnt, m_rld, n_cnt;
  logic m_gate, m_ct, m_tf, m_tr, n_tf;
  logic [3:0] m_sp;
  logic m_pend, m_t0a, m_t0b, m_t0p, m_ga, m_gb;
  logic fall, src, incm, cw, wrp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_gate = 0; m_ct = 0; m_tf = 0; m_tr = 0; m_sp = 0;
      m_pend = 0; m_t0a = 0; m_t0b = 0; m_t0p = 0; m_ga = 0; m_gb = 0;
    end else begin
      fall = m_t0p && !m_t0b;
      src  = mc_tick && (m_ct ? (m_pend || fall) : 1'b1);
      incm = m_tr && (!m_gate || m_gb) && src;
      cw   = wr_en && (wr_addr == 1 || wr_addr == 2);
      n_cnt = m_cnt; wrp = 0;
      if (cw) begin
        if (wr_addr == 1) n_cnt[7:0] = wr_data; else n_cnt[15:8] = wr_data;
      end else if (incm) begin
        if (m_cnt == 16'hFFFF) begin n_cnt = m_rld; wrp = 1; end
        else n_cnt = m_cnt + 16'd1;
      end
      n_tf = m_tf;
      if (wrp) n_tf = 1;
      else if (flag_clr) n_tf = 0;
      else if (wr_en && wr_addr == 0) n_tf = wr_data[5];
      if (wr_en && wr_addr == 0) begin
        m_gate = wr_data[7]; m_ct = wr_data[6]; m_tr = wr_data[4]; m_sp = wr_data[3:0];
      end
      if (wr_en && wr_addr == 3) m_rld[7:0]  = wr_data;
      if (wr_en && wr_addr == 4) m_rld[15:8] = wr_data;
      m_cnt = n_cnt; m_tf = n_tf;
      m_pend = mc_tick ? 1'b0 : (m_pend || fall);
      m_t0p = m_t0b; m_t0b = m_t0a; m_t0a = ext_cnt_pin;
      m_gb = m_ga; m_ga = ext_gate_pin;
    end
  end

  function automatic logic [7:0] exp_rd(int a);
    case (a)
      0: return {m_gate, m_ct, m_tf, m_tr, m_sp};
      1: return m_cnt[7:0];
      2: return m_cnt[15:8];
      3: return m_rld[7:0];
      4: return m_rld[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.2;
      obs[a] = rd_data;
      if (a == 0) chk("R9 ctrl", rd_data, exp_rd(a));
      else if (a < 3) chk("R2 count", rd_data, exp_rd(a));
      else if (a < 5) chk("R5 reload", rd_data, exp_rd(a));
      else chk("R10 unmapped", rd_data, exp_rd(a));
    end
    chk("R6 flag", ovf_flag, m_tf);
  end

  // tick source: 0 none, 1 every clock, 2 every twelfth clock
  always @(negedge clk) begin
    ph = (ph == 11) ? 0 : ph + 1;
    mc_tick <= (tick_mode == 1) || (tick_mode == 2 && ph == 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look();
    #3;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); look();
    for (int a = 0; a < 5; a++) chk("R1 reset reg", obs[a], 0);
    chk("R1 reset flag", ovf_flag, 0);
    chk("R10 unmapped read", obs[6], 0);

    // A: wrap in timer mode with tick every clock
    tick_mode = 1;
    wr(3, 8'h34); wr(4, 8'h12); wr(1, 8'hFD); wr(2, 8'hFF);
    wr(0, 8'h10);
    cyc(3); look();
    chk("R5 reload on wrap lo", obs[1], 8'h34);
    chk("R5 reload on wrap hi", obs[2], 8'h12);
    chk("R5 reload kept", {obs[4], obs[3]}, 16'h1234);
    chk("R6 flag set", ovf_flag, 1);
    wr(0, 8'h20);
    cyc(5); look();
    chk("R11 hold when stopped", {obs[2], obs[1]}, 16'h1236);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0; look();
    chk("R7 clear strobe", ovf_flag, 0);

    // B: overflow coincides with a clear strobe
    wr(2, 8'hFF); wr(1, 8'hFF); wr(0, 8'h10);
    flag_clr = 1;
    @(negedge clk); flag_clr = 0; look();
    chk("R7 overflow beats clear", ovf_flag, 1);
    chk("R5 reload after coincident wrap", {obs[2], obs[1]}, 16'h1234);

    // C: write beats increment
    wr(1, 8'h55); look();
    chk("R8 write over increment", obs[1], 8'h55);
    chk("R8 high byte untouched", obs[2], 8'h12);
    wr(0, 8'h0A); look();
    chk("R9 spare bits and layout", obs[0], 8'h0A);

    // D: gate
    wr(1, 0); wr(2, 0); wr(0, 8'h90);
    cyc(20); look();
    chk("R4 gate low holds", {obs[2], obs[1]}, 0);
    @(negedge clk); ext_gate_pin = 1;
    cyc(10); ext_gate_pin = 0;
    cyc(8); look();
    chk("R4 gate high counts", {obs[2], obs[1]}, 10);

    // E: external count pin
    wr(0, 8'h00); wr(1, 0); wr(2, 0);
    tick_mode = 2;
    wr(0, 8'h50);
    for (int k = 0; k < 5; k++) begin
      ext_cnt_pin = 0; cyc(15); ext_cnt_pin = 1; cyc(15);
    end
    cyc(20); look();
    chk("R3 one count per edge", {obs[2], obs[1]}, 5);
    tick_mode = 0; cyc(2);
    for (int k = 0; k < 3; k++) begin
      ext_cnt_pin = 0; cyc(2); ext_cnt_pin = 1; cyc(2);
    end
    cyc(6); look();
    chk("R3 edges wait for tick", {obs[2], obs[1]}, 5);
    tick_mode = 2; cyc(30); look();
    chk("R3 burst gives one count", {obs[2], obs[1]}, 6);

    // F: random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 100 == 0) tick_mode = $urandom_range(0, 2);
      ext_cnt_pin  = $urandom_range(0, 1);
      ext_gate_pin = $urandom_range(0, 3) != 0;
      flag_clr     = ($urandom_range(0, 15) == 0);
      wr_en        = ($urandom_range(0, 7) == 0);
      wr_addr      = 3'($urandom_range(0, 7));
      wr_data      = 8'($urandom_range(0, 255));
      if (wr_addr == 2 && $urandom_range(0, 1) == 1) wr_data = 8'hFF;
      if (wr_addr == 0) wr_data[4] = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    wr_en = 0; flag_clr = 0;
    cyc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule